// File: doc/BRIEF.md
# Configuration Address Type Translator

This block sits in the address phase of a bridge's configuration path. Each cycle it may accept a captured configuration address together with the bridge's secondary and subordinate bus numbers. From these it decides how the bridge treats the access. The access can be rewritten as a Type 0 access on the local secondary bus, passed on unchanged as a Type 1 access to a bus further down, turned into a special cycle, or left unclaimed.

On a Type 0 rewrite, the device number is decoded into a single select line on the upper address bits and the device field is cleared. On the same cycle the block raises two flags. One says that the downstream access is limited to one 32-bit data transfer. The other says that the access will end in a master abort because no select line was driven. The result is registered and appears one cycle after the input, marked by an output valid pulse.

Top module: `cfg_type_xlate`

## Requirements
- R1: On a Type 0 rewrite with device number (input bits 15:11) from 0 to 15, exactly one bit of output bits 31:16 is high, namely bit 16 + device number.
- R2: On a Type 0 rewrite with device number 16 to 30, output bits 31:16 are all zero and the outcome code is still 01 (Type 0).
- R3: Device number 31 with register field (input bits 7:2) equal to zero, on the local bus, gives outcome code 11 (special cycle), with output bits 31:11 zero and bits 1:0 zero.
- R4: On a Type 0 or special-cycle rewrite, output bits 15:11 and 1:0 are zero and bits 10:2 (function and register fields) equal the input. Device 31 with a nonzero register field is an ordinary Type 0 rewrite with no select line.
- R5: The master-abort flag is high exactly when the outcome is Type 0 and no select bit is driven.
- R6: When the bus number (input bits 23:16) is above the secondary bus number and no greater than the subordinate bus number, the outcome code is 10, the output address equals the input, and both flags are low.
- R7: The single-transfer flag is high exactly when the outcome code is 01.
- R8: An input whose bits 1:0 are not 01 is not a Type 1 access. It gives outcome code 00, the output address equals the input, and both flags are low.
- R9: A bus number equal to the secondary bus number always selects a rewrite, even if the subordinate number is smaller. A bus number below the secondary or above the subordinate (and not equal to the secondary) gives outcome code 00 with the address unchanged and both flags low.
- R10: A valid input is reflected one clock later with `out_valid` high for one cycle per input. When no input is valid, `out_valid` is low and the other outputs hold their last values.
- R11: Synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input address is present this cycle |
| in_addr | input | 32 | Captured configuration address |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| out_valid | output | 1 | Result valid pulse |
| out_kind | output | 2 | Outcome: 00 ignore, 01 Type 0, 10 Type 1 pass, 11 special cycle |
| out_addr | output | 32 | Rewritten or forwarded address |
| out_mabort | output | 1 | Downstream access will master-abort (no select line) |
| out_single | output | 1 | Access limited to one 32-bit data transfer |

## Verification
The two flags can both be raised in the same result. This happens when a local-bus access names a device from 16 to 30, or device 31 with a nonzero register field: the single-transfer limit and the master-abort prediction are then set together. The bench provokes this by sweeping every device number on the secondary bus. It judges both flags on each result against a behavioural model. For devices 0 to 15 only the single-transfer flag may be set, and for a special cycle neither flag may be set.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        KIND_IGNORE  = 2'b00,
        KIND_TYPE0   = 2'b01,
        KIND_PASS1   = 2'b10,
        KIND_SPECIAL = 2'b11
    } xlate_kind_e;

    typedef struct packed {
        logic              vld;
        xlate_kind_e       kind;
        logic [ADDR_W-1:0] addr;
        logic              mabort;
        logic              single;
    } xlate_res_t;
endpackage

// File: rtl/cfg_bus_window.sv
module cfg_bus_window #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] tgt_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output logic             hit_local,
    output logic             hit_below
);
    always_comb begin
        hit_local = (tgt_bus == sec_bus);
        hit_below = !hit_local && (tgt_bus > sec_bus) && (tgt_bus <= sub_bus);
    end
endmodule

// File: rtl/cfg_idsel_onehot.sv
module cfg_idsel_onehot #(
    parameter int DEV_W = 5,
    parameter int LINES = 16
) (
    input  logic [DEV_W-1:0] dev_num,
    output logic [LINES-1:0] sel_lines,
    output logic             sel_any
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign sel_lines[i] = (dev_num == DEV_W'(i));
    end
    assign sel_any = |sel_lines;
endmodule

// File: rtl/cfg_type_xlate.sv
module cfg_type_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int BUS_LSB     = 16,
    parameter int DEV_W       = 5,
    parameter int DEV_LSB     = 11,
    parameter int REG_W       = 6,
    parameter int REG_LSB     = 2,
    parameter int IDSEL_LSB   = 16,
    parameter int IDSEL_LINES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_mabort,
    output logic              out_single
);
    localparam logic [DEV_W-1:0] DEV_SPECIAL = {DEV_W{1'b1}};
    localparam logic [1:0]       TYPE1_CODE  = 2'b01;

    xlate_res_t res_d, res_q;

    logic [BUS_W-1:0]       tgt_bus;
    logic [DEV_W-1:0]       dev_num;
    logic [REG_W-1:0]       reg_num;
    logic                   hit_local, hit_below;
    logic [IDSEL_LINES-1:0] sel_lines;
    logic                   sel_any;
    logic                   is_type1, is_special;
    logic [ADDR_W-1:0]      conv_addr;

    assign tgt_bus = in_addr[BUS_LSB +: BUS_W];
    assign dev_num = in_addr[DEV_LSB +: DEV_W];
    assign reg_num = in_addr[REG_LSB +: REG_W];

    cfg_bus_window #(.BUS_W(BUS_W)) u_window (
        .tgt_bus  (tgt_bus),
        .sec_bus  (sec_bus),
        .sub_bus  (sub_bus),
        .hit_local(hit_local),
        .hit_below(hit_below)
    );

    cfg_idsel_onehot #(.DEV_W(DEV_W), .LINES(IDSEL_LINES)) u_idsel (
        .dev_num  (dev_num),
        .sel_lines(sel_lines),
        .sel_any  (sel_any)
    );

    always_comb begin
        is_type1   = (in_addr[1:0] == TYPE1_CODE);
        is_special = (dev_num == DEV_SPECIAL) && (reg_num == '0);

        conv_addr                            = in_addr;
        conv_addr[ADDR_W-1:IDSEL_LSB]        = '0;
        conv_addr[DEV_LSB +: DEV_W]          = '0;
        conv_addr[1:0]                       = 2'b00;
        if (!is_special) begin
            conv_addr[IDSEL_LSB +: IDSEL_LINES] = sel_lines;
        end

        res_d     = res_q;
        res_d.vld = 1'b0;
        if (in_valid) begin
            res_d.vld    = 1'b1;
            res_d.kind   = KIND_IGNORE;
            res_d.addr   = in_addr;
            res_d.mabort = 1'b0;
            res_d.single = 1'b0;
            if (is_type1 && hit_local) begin
                res_d.addr = conv_addr;
                if (is_special) begin
                    res_d.kind = KIND_SPECIAL;
                end else begin
                    res_d.kind   = KIND_TYPE0;
                    res_d.single = 1'b1;
                    res_d.mabort = !sel_any;
                end
            end else if (is_type1 && hit_below) begin
                res_d.kind = KIND_PASS1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.vld;
    assign out_kind   = res_q.kind;
    assign out_addr   = res_q.addr;
    assign out_mabort = res_q.mabort;
    assign out_single = res_q.single;
endmodule

// File: rtl/cfg_type_xlate_chk.sv
module cfg_type_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_addr,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic [31:0] out_addr,
    input logic        out_mabort,
    input logic        out_single
);
    AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'b01 && !out_mabort) |-> ($countones(out_addr[31:16]) == 1)); // R1
    AST_SPECIAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'b11) |-> (out_addr[31:11] == '0 && out_addr[1:0] == 2'b00)); // R3
    AST_FIELDS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind[0]) |-> (out_addr[15:11] == '0 && out_addr[10:2] == $past(in_addr[10:2]))); // R4
    AST_ABORT_MATCH: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'b01) |-> (out_mabort == (out_addr[31:16] == '0))); // R5
    AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'b10) |-> (out_addr == $past(in_addr) && !out_mabort)); // R6
    AST_SINGLE_T0: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_single == (out_kind == 2'b01))); // R7
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> ($stable(out_addr) && $stable(out_kind))); // R10
endmodule

bind cfg_type_xlate cfg_type_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_addr  (out_addr),
    .out_mabort(out_mabort),
    .out_single(out_single)
);

// File: tb/tb_cfg_type_xlate.sv
`timescale 1ns/1ps
module tb_cfg_type_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [7:0]  sec_bus = '0;
    logic [7:0]  sub_bus = '0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [31:0] out_addr;
    logic        out_mabort;
    logic        out_single;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0]  e_kind = '0;
    logic [31:0] e_addr = '0;
    logic        e_mab  = 1'b0;
    logic        e_sgl  = 1'b0;

    always #2 clk = ~clk;

    cfg_type_xlate dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .out_valid(out_valid),
        .out_kind(out_kind), .out_addr(out_addr), .out_mabort(out_mabort),
        .out_single(out_single)
    );

    task automatic model(input logic [31:0] a, input int sb, input int ub);
        int bus, dev, rg;
        bus = int'(a[23:16]);
        dev = int'(a[15:11]);
        rg  = int'(a[7:2]);
        e_kind = 2'b00; e_addr = a; e_mab = 1'b0; e_sgl = 1'b0;
        if (a[1:0] == 2'b01) begin
            if (bus == sb) begin
                e_addr = a & 32'h0000_07FC;
                if (dev == 31 && rg == 0) begin
                    e_kind = 2'b11;
                end else begin
                    e_kind = 2'b01;
                    e_sgl  = 1'b1;
                    if (dev < 16) e_addr = e_addr | (32'h1 << (16 + dev));
                    else e_mab = 1'b1;
                end
            end else if (bus > sb && bus <= ub) begin
                e_kind = 2'b10;
            end
        end
    endtask

    task automatic compare(input string tag, input logic exp_v);
        checks++;
        if (out_valid !== exp_v || out_kind !== e_kind || out_addr !== e_addr ||
            out_mabort !== e_mab || out_single !== e_sgl) begin
            errors++;
            $display("FAIL %s: got v=%b k=%b a=%h m=%b s=%b expected v=%b k=%b a=%h m=%b s=%b",
                     tag, out_valid, out_kind, out_addr, out_mabort, out_single,
                     exp_v, e_kind, e_addr, e_mab, e_sgl);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [31:0] a,
                        input int sb, input int ub);
        in_valid = v; in_addr = a; sec_bus = 8'(sb); sub_bus = 8'(ub);
        if (v) model(a, sb, ub);
        @(negedge clk);
        compare(tag, v);
    endtask

    function automatic logic [31:0] mk(input int bus, input int dev, input int fn,
                                       input int rg, input int t);
        return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'(t)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        compare("R11", 1'b0);
        rst = 1'b0;
        for (int d = 0; d < 16; d++) step("R1", 1'b1, mk(5, d, d % 8, d + 1, 1), 5, 9);
        for (int d = 16; d < 31; d++) step("R2", 1'b1, mk(5, d, 3, 10, 1), 5, 9);
        step("R3", 1'b1, mk(5, 31, 6, 0, 1), 5, 9);
        step("R4", 1'b1, mk(5, 31, 2, 7, 1), 5, 9);
        step("R4", 1'b1, mk(5, 9, 7, 63, 1) | 32'hAB00_0000, 5, 9);
        step("R5", 1'b1, mk(5, 20, 1, 1, 1), 5, 9);
        step("R6", 1'b1, mk(6, 3, 2, 4, 1), 5, 9);
        step("R6", 1'b1, mk(9, 31, 0, 0, 1) | 32'h5A00_0000, 5, 9);
        step("R7", 1'b1, mk(5, 0, 0, 0, 1), 5, 9);
        step("R8", 1'b1, mk(5, 2, 1, 1, 0), 5, 9);
        step("R8", 1'b1, mk(5, 2, 1, 1, 3), 5, 9);
        step("R8", 1'b1, mk(6, 2, 1, 1, 2), 5, 9);
        step("R9", 1'b1, mk(10, 2, 1, 1, 1), 5, 9);
        step("R9", 1'b1, mk(4, 2, 1, 1, 1), 5, 9);
        step("R9", 1'b1, mk(7, 4, 0, 2, 1), 7, 3);
        step("R9", 1'b1, mk(5, 4, 0, 2, 1), 7, 3);
        step("R10", 1'b1, mk(5, 12, 0, 2, 1), 5, 9);
        step("R10", 1'b0, 32'hFFFF_FFFF, 5, 9);
        step("R10", 1'b0, 32'h0, 0, 0);
        step("R10", 1'b1, mk(7, 1, 0, 0, 1), 5, 9);
        begin
            logic [31:0] lf = 32'hACE1_1234;
            for (int i = 0; i < 300; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                lf[1:0] = (i % 4 == 3) ? lf[1:0] : 2'b01;
                step("R10", lf[2], lf, int'(lf[23:21]) + 1, int'(lf[26:24]) + 4);
            end
        end
        rst = 1'b1;
        @(negedge clk);
        e_kind = '0; e_addr = '0; e_mab = 1'b0; e_sgl = 1'b0;
        compare("R11", 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule